// File: doc/BRIEF.md
# Multi-format stereo PCM serial receiver

This block takes a three-wire serial audio link (a bit clock, a word-select clock and one data line) and turns it into parallel left and right samples. All three lines are oversampled by the system clock. Each rising edge of the serial bit clock becomes one internal bit tick, and every framing decision is taken on those ticks. A static select input chooses right-justified or I2S framing. Two further framings are found by counting bit ticks. A word-select high pulse of four ticks or fewer switches the receiver to DSP framing. A half frame of exactly sixteen ticks switches it to packed 16-bit words.

Samples leave the block 24 bits wide, aligned to the MSB. Shorter words are padded with zeros in their low bits. A left/right pair appears together with a single-cycle valid strobe, and the outputs hold their value until the next pair. The detected framing is brought out on two flags. Each flag is re-decided only at the word-select edges that measure it, so a framing stays in force for as long as the link timing stays the same.

Top module: `pcm_serial_rx`

## Requirements
- R1: Data is taken MSB first in every framing. Outputs are 24 bits wide and aligned to the MSB, and the unused low bits of shorter words read as zero.
- R2: With fmt_sel_i low and DSP not detected, right-justified framing applies. wsel high marks the left word and wsel low marks the right word. Each word is the last 16 bits sampled before the wsel edge that ends it, and it is output as {word,8'h00}.
- R3: With fmt_sel_i high and DSP not detected, I2S framing applies. wsel low marks the left word and wsel high marks the right word. The MSB is taken on the second bit-clock rise after the wsel edge, and 24 bits are taken per word.
- R4: A wsel high phase lasting four bit ticks or fewer sets dsp_mode_o, and a high phase of five ticks or more clears it. The flag is re-decided only at each wsel falling edge.
- R5: In DSP framing, 48 consecutive bits are taken: the left word, then the right word at once. With fmt_sel_i low (variant A), the left MSB is taken on the second bit-clock rise after wsel rises. With fmt_sel_i high (variant B), it is taken on the first.
- R6: A wsel phase of exactly 16 bit ticks sets packed_mode_o, and any other length clears it. The flag is re-decided at every wsel edge. While it is set, I2S words are 16 bits long and are output as {word,8'h00}.
- R7: pair_valid_o pulses for one cycle per completed pair. The pulse comes at the wsel falling edge in I2S, at the wsel rising edge in right-justified framing, and on the last right-word bit in DSP framing. left_o and right_o change only with that pulse.
- R8: Every pair_valid_o pulse comes exactly 3 system-clock cycles after the bit-clock rise that completes the pair.
- R9: While rst_n is low, all outputs read zero.
- R10: In I2S framing, bits that arrive after the 24th (or, when packed, the 16th) bit of a phase are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for oversampling |
| rst_n | input | 1 | Active-low reset |
| sck_i | input | 1 | Serial bit clock; data is taken on its rise |
| wsel_i | input | 1 | Word-select clock |
| sdata_i | input | 1 | Serial data |
| fmt_sel_i | input | 1 | 0: right-justified / DSP variant A; 1: I2S / DSP variant B |
| left_o | output | 24 | Left sample, aligned to the MSB |
| right_o | output | 24 | Right sample, aligned to the MSB |
| pair_valid_o | output | 1 | One-cycle strobe for a new pair |
| dsp_mode_o | output | 1 | DSP framing detected |
| packed_mode_o | output | 1 | Packed 16-tick half frames detected |

## Verification
Every result is due exactly three system-clock cycles after the bit-clock rise that completes it. Two synchronizer stages and the output register make up that delay. The bench records the cycle of each bit-clock rise it drives and checks that delay on every strobe. It collects pairs in a queue and compares the tail of the queue with the frames it sent. Frames sent while a framing is still being detected are skipped, and any frame whose pair is only finished by the next wsel edge is followed by a trailing frame. The mode flags are read at the port only after the wsel edge that measures them has been sent.

// File: rtl/pcm_rx_pkg.sv
package pcm_rx_pkg;

  typedef enum logic [1:0] {
    FMT_RJ    = 2'd0,
    FMT_I2S   = 2'd1,
    FMT_DSP_A = 2'd2,
    FMT_DSP_B = 2'd3
  } frame_fmt_e;

  // Framing in force: detected DSP overrides the pin, the pin picks the variant.
  function automatic frame_fmt_e pick_fmt(input logic sel, input logic dsp);
    if (dsp) return sel ? FMT_DSP_B : FMT_DSP_A;
    return sel ? FMT_I2S : FMT_RJ;
  endfunction

  function automatic logic is_dsp(input frame_fmt_e f);
    return (f == FMT_DSP_A) || (f == FMT_DSP_B);
  endfunction

endpackage

// File: rtl/pcm_rx_bit_sync.sv
module pcm_rx_bit_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_i,
  input  logic ws_i,
  input  logic sd_i,
  output logic tick_o,
  output logic ws_o,
  output logic sd_o
);
  logic [STAGES-1:0] sck_p, ws_p, sd_p;
  logic              sck_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_p    <= '0;
      ws_p     <= '0;
      sd_p     <= '0;
      sck_last <= 1'b0;
    end else begin
      sck_p    <= {sck_p[STAGES-2:0], sck_i};
      ws_p     <= {ws_p[STAGES-2:0], ws_i};
      sd_p     <= {sd_p[STAGES-2:0], sd_i};
      sck_last <= sck_p[STAGES-1];
    end
  end

  assign tick_o = sck_p[STAGES-1] & ~sck_last;
  assign ws_o   = ws_p[STAGES-1];
  assign sd_o   = sd_p[STAGES-1];
endmodule

// File: rtl/pcm_rx_frame_timer.sv
module pcm_rx_frame_timer #(
  parameter int CNT_W    = 8,
  parameter int DSP_MAX  = 4,
  parameter int PACK_LEN = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             ws,
  output logic             ws_rise,
  output logic             ws_fall,
  output logic [CNT_W-1:0] phase_len,
  output logic [CNT_W-1:0] rise_idx,
  output logic             dsp_o,
  output logic             packed_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] DSP_LIM = CNT_W'(DSP_MAX);
  localparam logic [CNT_W-1:0] PACK_N  = CNT_W'(PACK_LEN);

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == CNT_MAX) ? v : v + 1'b1;
  endfunction

  logic             ws_q;
  logic [CNT_W-1:0] pos, rpos;

  assign ws_rise   = tick & ws & ~ws_q;
  assign ws_fall   = tick & ~ws & ws_q;
  // ticks in the phase ending now, counting this tick
  assign phase_len = sat_inc(pos);
  // index of this tick counted from the last wsel rise
  assign rise_idx  = ws_rise ? '0 : sat_inc(rpos);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ws_q     <= 1'b0;
      pos      <= '0;
      rpos     <= CNT_MAX;
      dsp_o    <= 1'b0;
      packed_o <= 1'b0;
    end else if (tick) begin
      ws_q <= ws;
      pos  <= (ws_rise | ws_fall) ? '0 : phase_len;
      rpos <= rise_idx;
      if (ws_fall) dsp_o <= (phase_len <= DSP_LIM);
      if (ws_rise | ws_fall) packed_o <= (phase_len == PACK_N);
    end
  end
endmodule

// File: rtl/pcm_rx_word_capture.sv
module pcm_rx_word_capture
  import pcm_rx_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int RJ_W     = 16,
  parameter int PACK_LEN = 16,
  parameter int CNT_W    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                sd,
  input  logic                ws_rise,
  input  logic                ws_fall,
  input  logic [CNT_W-1:0]    phase_len,
  input  logic [CNT_W-1:0]    rise_idx,
  input  frame_fmt_e          fmt,
  input  logic                packed_on,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o,
  output logic                valid_o
);
  localparam int SR_W = 2 * SAMPLE_W;
  localparam logic [CNT_W-1:0] LAST_A = CNT_W'(SR_W);
  localparam logic [CNT_W-1:0] LAST_B = CNT_W'(SR_W - 1);
  localparam logic [CNT_W-1:0] WL_FULL = CNT_W'(SAMPLE_W);
  localparam logic [CNT_W-1:0] WL_PACK = CNT_W'(PACK_LEN);

  // move an n-bit word held in the low bits up to the MSB end
  function automatic logic [SAMPLE_W-1:0] msb_align(input logic [SAMPLE_W-1:0] bits, input int unsigned n);
    return bits << (SAMPLE_W - n);
  endfunction

  logic [SR_W-1:0]     sr, sr_nx;
  logic [SAMPLE_W-1:0] hold_l, i2s_word, rj_word;
  logic [CNT_W-1:0]    i2s_wl, dsp_last;
  logic                shift_en;

  assign i2s_wl   = packed_on ? WL_PACK : WL_FULL;
  assign shift_en = (fmt != FMT_I2S) || (phase_len <= i2s_wl);
  assign sr_nx    = shift_en ? {sr[SR_W-2:0], sd} : sr;
  assign i2s_word = packed_on ? msb_align(sr_nx[SAMPLE_W-1:0], PACK_LEN) : sr_nx[SAMPLE_W-1:0];
  assign rj_word  = msb_align(sr[SAMPLE_W-1:0], RJ_W);
  assign dsp_last = (fmt == FMT_DSP_A) ? LAST_A : LAST_B;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr      <= '0;
      hold_l  <= '0;
      left_o  <= '0;
      right_o <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (tick) begin
        sr <= sr_nx;
        unique case (fmt)
          FMT_I2S: begin
            if (ws_rise) hold_l <= i2s_word;
            if (ws_fall) begin
              left_o  <= hold_l;
              right_o <= i2s_word;
              valid_o <= 1'b1;
            end
          end
          FMT_RJ: begin
            if (ws_fall) hold_l <= rj_word;
            if (ws_rise) begin
              left_o  <= hold_l;
              right_o <= rj_word;
              valid_o <= 1'b1;
            end
          end
          default: begin
            if (is_dsp(fmt) && rise_idx == dsp_last) begin
              left_o  <= sr_nx[SR_W-1:SAMPLE_W];
              right_o <= sr_nx[SAMPLE_W-1:0];
              valid_o <= 1'b1;
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/pcm_serial_rx.sv
module pcm_serial_rx
  import pcm_rx_pkg::*;
#(
  parameter int SAMPLE_W    = 24,
  parameter int RJ_W        = 16,
  parameter int PACK_LEN    = 16,
  parameter int DSP_MAX     = 4,
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sck_i,
  input  logic                wsel_i,
  input  logic                sdata_i,
  input  logic                fmt_sel_i,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o,
  output logic                pair_valid_o,
  output logic                dsp_mode_o,
  output logic                packed_mode_o
);
  logic             bit_tick, ws_s, sd_s;
  logic             ws_rise, ws_fall;
  logic [CNT_W-1:0] phase_len, rise_idx;
  frame_fmt_e       cur_fmt;

  pcm_rx_bit_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sck_i(sck_i), .ws_i(wsel_i), .sd_i(sdata_i),
    .tick_o(bit_tick), .ws_o(ws_s), .sd_o(sd_s)
  );

  pcm_rx_frame_timer #(.CNT_W(CNT_W), .DSP_MAX(DSP_MAX), .PACK_LEN(PACK_LEN)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(bit_tick), .ws(ws_s),
    .ws_rise(ws_rise), .ws_fall(ws_fall), .phase_len(phase_len), .rise_idx(rise_idx),
    .dsp_o(dsp_mode_o), .packed_o(packed_mode_o)
  );

  assign cur_fmt = pick_fmt(fmt_sel_i, dsp_mode_o);

  pcm_rx_word_capture #(.SAMPLE_W(SAMPLE_W), .RJ_W(RJ_W), .PACK_LEN(PACK_LEN), .CNT_W(CNT_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .tick(bit_tick), .sd(sd_s),
    .ws_rise(ws_rise), .ws_fall(ws_fall), .phase_len(phase_len), .rise_idx(rise_idx),
    .fmt(cur_fmt), .packed_on(packed_mode_o),
    .left_o(left_o), .right_o(right_o), .valid_o(pair_valid_o)
  );
endmodule

// File: rtl/pcm_serial_rx_chk.sv
module pcm_serial_rx_chk
  import pcm_rx_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int RJ_W     = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                tick,
  input logic                ws_rise,
  input logic                ws_fall,
  input frame_fmt_e          fmt,
  input logic                pair_valid,
  input logic [SAMPLE_W-1:0] left,
  input logic [SAMPLE_W-1:0] right,
  input logic                dsp,
  input logic                packed_on
);
  localparam int PAD = SAMPLE_W - RJ_W;

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid |=> !pair_valid);

  a_r8_valid_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid |-> $past(tick));

  a_r4_dsp_at_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dsp) |-> $past(ws_fall));

  a_r6_packed_at_edge: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(packed_on) |-> $past(ws_rise || ws_fall));

  a_r7_left_held: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(left) |-> pair_valid);

  a_r7_right_held: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(right) |-> pair_valid);

  a_r2_rj_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_valid && $past(fmt) == FMT_RJ) |-> (right[PAD-1:0] == '0 && left[PAD-1:0] == '0));
endmodule

bind pcm_serial_rx pcm_serial_rx_chk #(.SAMPLE_W(SAMPLE_W), .RJ_W(RJ_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(bit_tick), .ws_rise(ws_rise), .ws_fall(ws_fall),
  .fmt(cur_fmt), .pair_valid(pair_valid_o), .left(left_o), .right(right_o),
  .dsp(dsp_mode_o), .packed_on(packed_mode_o)
);

// File: tb/pcm_serial_rx_bench.sv
module pcm_serial_rx_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, sck, ws, sd, fmt_sel, pend;
  logic [23:0] left_o, right_o;
  logic pair_valid_o, dsp_mode_o, packed_mode_o;

  int cyc = 0;
  int rise_cyc = 0;
  int checks = 0;
  int fails = 0;
  logic [23:0] cap_l[$], cap_r[$];
  logic [23:0] exp_l[8], exp_r[8];

  pcm_serial_rx u_pcm_serial_rx (
    .clk(clk), .rst_n(rst_n), .sck_i(sck), .wsel_i(ws), .sdata_i(sd), .fmt_sel_i(fmt_sel),
    .left_o(left_o), .right_o(right_o), .pair_valid_o(pair_valid_o),
    .dsp_mode_o(dsp_mode_o), .packed_mode_o(packed_mode_o)
  );

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [47:0] act, input logic [47:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  // R8: collect pairs and check the latency from the completing bit-clock rise
  always @(negedge clk) begin
    if (rst_n && pair_valid_o) begin
      cap_l.push_back(left_o);
      cap_r.push_back(right_o);
      check((cyc - rise_cyc) == 3, "R8", "strobe latency", 48'(cyc - rise_cyc), 48'd3);
    end
  end

  function automatic logic rbit();
    return 1'($urandom % 2);
  endfunction

  task automatic slot(input logic w, input logic d);
    @(negedge clk);
    sck = 1'b0; ws = w; sd = d;
    repeat (4) @(negedge clk);
    sck = 1'b1;
    rise_cyc = cyc;
    repeat (3) @(negedge clk);
  endtask

  // I2S: data runs one tick behind wsel
  task automatic i2s_half(input logic w, input logic [23:0] word, input int h, input int wl);
    for (int s = 0; s < h; s++) begin
      logic d;
      d = (s < wl) ? word[23 - s] : rbit();
      slot(w, pend);
      pend = d;
    end
  endtask

  task automatic rj_half(input logic w, input logic [15:0] word, input int h);
    for (int s = 0; s < h; s++) begin
      logic d;
      d = (s >= h - 16) ? word[15 - (s - (h - 16))] : rbit();
      slot(w, d);
    end
  endtask

  task automatic dsp_frame(input logic [23:0] l, input logic [23:0] r, input int pw, input bit var_b);
    logic [47:0] both;
    both = {l, r};
    for (int s = 0; s < 64; s++) begin
      int idx;
      logic d;
      idx = s - (var_b ? 0 : 1);
      d = (idx >= 0 && idx < 48) ? both[47 - idx] : rbit();
      slot(s < pw, d);
    end
  endtask

  task automatic compare_tail(input int first, input int last, input string req);
    int n, base;
    n = last - first + 1;
    base = cap_l.size() - n;
    if (base < 0) begin
      check(1'b0, req, "pair count", 48'(cap_l.size()), 48'(n));
    end else begin
      for (int t = 0; t < n; t++) begin
        check(cap_l[base + t] == exp_l[first + t], req, "left", 48'(cap_l[base + t]), 48'(exp_l[first + t]));
        check(cap_r[base + t] == exp_r[first + t], req, "right", 48'(cap_r[base + t]), 48'(exp_r[first + t]));
      end
    end
  endtask

  task automatic run_i2s(input int nf, input int h, input int wl, input string req);
    cap_l.delete(); cap_r.delete();
    fmt_sel = 1'b1;
    for (int f = 0; f < nf; f++) begin
      exp_l[f] = (wl == 16) ? {16'($urandom), 8'h00} : 24'($urandom);
      exp_r[f] = (wl == 16) ? {16'($urandom), 8'h00} : 24'($urandom);
      i2s_half(1'b0, exp_l[f], h, wl);
      i2s_half(1'b1, exp_r[f], h, wl);
    end
    i2s_half(1'b0, 24'h0, h, wl);
    i2s_half(1'b1, 24'h0, h, wl);
    repeat (10) @(negedge clk);
    compare_tail(1, nf - 1, req);
  endtask

  task automatic run_rj(input int nf, input int h, input string req);
    cap_l.delete(); cap_r.delete();
    fmt_sel = 1'b0;
    for (int f = 0; f < nf; f++) begin
      logic [15:0] wl16, wr16;
      wl16 = 16'($urandom);
      wr16 = 16'($urandom);
      exp_l[f] = {wl16, 8'h00};
      exp_r[f] = {wr16, 8'h00};
      rj_half(1'b1, wl16, h);
      rj_half(1'b0, wr16, h);
    end
    rj_half(1'b1, 16'h0, h);
    rj_half(1'b0, 16'h0, h);
    repeat (10) @(negedge clk);
    compare_tail(1, nf - 1, req);
  endtask

  task automatic run_dsp(input int nf, input int pw, input bit var_b, input string req);
    cap_l.delete(); cap_r.delete();
    fmt_sel = var_b;
    for (int f = 0; f < nf; f++) begin
      exp_l[f] = 24'($urandom);
      exp_r[f] = 24'($urandom);
      dsp_frame(exp_l[f], exp_r[f], pw, var_b);
    end
    repeat (10) @(negedge clk);
    compare_tail(1, nf - 1, req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=finished", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'h0000_5eed);
    rst_n = 1'b0; sck = 1'b0; ws = 1'b0; sd = 1'b0; fmt_sel = 1'b1; pend = 1'b0;
    repeat (5) @(negedge clk);
    // R9: reset state at the ports
    check(left_o == 24'h0 && right_o == 24'h0, "R9", "samples in reset", {left_o, right_o}, 48'h0);
    check(!pair_valid_o && !dsp_mode_o && !packed_mode_o, "R9", "flags in reset",
          48'({pair_valid_o, dsp_mode_o, packed_mode_o}), 48'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R3 R1 R10: I2S, 32-tick halves, random junk after bit 24
    run_i2s(6, 32, 24, "R3");
    check(!dsp_mode_o && !packed_mode_o, "R10", "I2S flags", 48'({dsp_mode_o, packed_mode_o}), 48'h0);

    // R6: packed I2S, 16 ticks per half
    run_i2s(6, 16, 16, "R6");
    check(packed_mode_o, "R6", "packed flag set", 48'(packed_mode_o), 48'h1);

    // R2: right-justified, 24-tick halves with junk ahead of each word
    run_rj(6, 24, "R2");
    check(!packed_mode_o, "R6", "packed flag clear", 48'(packed_mode_o), 48'h0);

    // R2: right-justified, packed halves
    run_rj(5, 16, "R2");

    // R5 R4: DSP variant A, one-tick pulse
    run_dsp(6, 1, 1'b0, "R5");
    check(dsp_mode_o, "R4", "dsp flag after 1-tick pulse", 48'(dsp_mode_o), 48'h1);

    // R5 R4: DSP variant B, four-tick pulse (boundary)
    run_dsp(6, 4, 1'b1, "R4");
    check(dsp_mode_o, "R4", "dsp flag after 4-tick pulse", 48'(dsp_mode_o), 48'h1);

    // R4: five-tick pulse is not a DSP frame
    dsp_frame(24'h123456, 24'h654321, 5, 1'b1);
    repeat (10) @(negedge clk);
    check(!dsp_mode_o, "R4", "dsp flag after 5-tick pulse", 48'(dsp_mode_o), 48'h0);

    // R3 R7: back to I2S after DSP
    run_i2s(4, 32, 24, "R7");
    check(!dsp_mode_o, "R4", "dsp flag in I2S", 48'(dsp_mode_o), 48'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule